// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Timer

This block drives the six gate signals of a three-phase inverter bridge. Each phase has a high-side and a low-side output. The two outputs of a phase are complementary, and a programmable gap separates one turning off from the other turning on. All edges are placed symmetrically about the middle of a fixed-length switching period. Pulses shorter than a programmable minimum are suppressed rather than emitted.

A single period counter serves all three phases. The period, dead time, minimum width and the three duty values are captured from the inputs only when a period begins, so software may rewrite them at any moment without tearing a waveform. A one-clock start pulse marks each period, for use as an interrupt or converter trigger.

A fault input blanks every output at once. The blanking is held until a clear request arrives and the next period starts. There is no dead-time guard across the period boundary: moving into or out of a fully-on setting can place both devices of a phase on in adjacent clocks. Keeping every duty at or below period − 2·(dead + 1), with the minimum width at zero, avoids that case.

Top module: `pwm3_center`

## Requirements
- R1: One switching period lasts `period_i` clocks, with `period_i` even and at least 2. `sync_o` is high for exactly the first clock of each period.
- R2: With zero dead time, the high output of a phase with even duty D is on for D consecutive clocks. These are positions P/2 − D/2 through P/2 + D/2 − 1 of the period.
- R3: With h = P/2 and the fold value c = pos for pos < h, else P − 1 − pos, the low output is on exactly while c < h − D/2.
- R4: The high output turns on only once c reaches h − D/2 plus the dead time. This leaves a gap of `dead_i` clocks at both edges.
- R5: High and low of the same phase are never on in the same clock.
- R6: If the high pulse width 2·(D/2 − dead) is below `minpw_i`, the high output stays off for the whole period.
- R7: If the low pulse width 2·(h − D/2) is below `minpw_i`, the low output stays off for the whole period.
- R8: A duty of P or more holds the high output on and the low output off for the whole period, with no dead-time gap at the boundary. A duty of 0 does the reverse.
- R9: Changes to period, dead time, minimum width or duty take effect only at the start of the next period.
- R10: `trip_i` forces all six outputs low in the same clock. They stay low until a `trip_clr_i` pulse has been seen and a new period has begun with `trip_i` low.
- R11: During reset all outputs and `sync_o` are low. The first period starts at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period length in clocks |
| dead_i | input | DT_W | Dead-time gap in clocks |
| minpw_i | input | CNT_W | Minimum pulse width; narrower pulses are suppressed |
| duty_a_i | input | CNT_W | Phase A high-side on-time in clocks |
| duty_b_i | input | CNT_W | Phase B high-side on-time in clocks |
| duty_c_i | input | CNT_W | Phase C high-side on-time in clocks |
| trip_i | input | 1 | Fault; blanks all outputs |
| trip_clr_i | input | 1 | Request to release a latched fault |
| hi_o | output | 3 | High-side gates, bit 0 = A, 1 = B, 2 = C |
| lo_o | output | 3 | Low-side gates, same bit order |
| sync_o | output | 1 | Period start pulse |

## Verification
The gate outputs are decoded combinationally from the registered period position, so each gate value belongs to the clock in which the position holds. The bench samples every output on the falling edge. The start pulse and newly captured settings appear one edge after the last position of the old period; the bench waits for the start pulse at the edge, then queues one expected item per position of the coming period. Fault blanking is checked in the same clock that `trip_i` rises, and the release is expected only after the next start pulse. Settings changed in mid-period are checked against items already queued with the old values.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned NPH = 3;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [CNT_W-1:0] minpw_i,
  output logic             load_o,
  output logic             sync_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] fold_o,
  output logic [CNT_W-1:0] half_o,
  output logic [DT_W-1:0]  dead_o,
  output logic [CNT_W-1:0] minpw_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pos_q, per_q, minpw_q;
  logic [DT_W-1:0]  dead_q;
  logic             sync_q, wrap;

  assign wrap = (per_q == '0) || (pos_q == per_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      per_q   <= '0;
      dead_q  <= '0;
      minpw_q <= '0;
      sync_q  <= 1'b0;
    end else if (wrap) begin
      pos_q   <= '0;
      per_q   <= period_i;
      dead_q  <= dead_i;
      minpw_q <= minpw_i;
      sync_q  <= 1'b1;
    end else begin
      pos_q  <= pos_q + ONE;
      sync_q <= 1'b0;
    end
  end

  assign half_o  = per_q >> 1;
  assign fold_o  = (pos_q < half_o) ? pos_q : (per_q - pos_q - ONE);
  assign valid_o = (per_q >= CNT_W'(2));
  assign load_o  = wrap;
  assign sync_o  = sync_q;
  assign dead_o  = dead_q;
  assign minpw_o = minpw_q;

  a_r1_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0) |-> (pos_q < per_q));
  a_r1_sync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && per_q > ONE) |=> !sync_q);
  a_r9_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |-> ($stable(per_q) && $stable(dead_q) && $stable(minpw_q)));
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] fold_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [CNT_W-1:0] minpw_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int unsigned W = CNT_W + 2;

  logic [CNT_W-1:0] duty_q;
  logic [W-1:0] dh, half_w, fold_w, dead_w, mp_w, thr, on_thr, w_hi, w_lo;
  logic full, hi_raw, lo_raw, hi_del, lo_del;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

  always_comb begin
    dh     = W'(duty_q) >> 1;
    half_w = W'(half_i);
    fold_w = W'(fold_i);
    dead_w = W'(dead_i);
    mp_w   = W'(minpw_i);
    thr    = (dh >= half_w) ? '0 : (half_w - dh);
    on_thr = thr + dead_w;
    full   = (thr == '0);
    w_hi   = (half_w > on_thr) ? ((half_w - on_thr) << 1) : '0;
    w_lo   = thr << 1;
    // full-on bypasses dead time: no guard across the period boundary
    hi_raw = full || (fold_w >= on_thr);
    lo_raw = (fold_w < thr);
    hi_del = !full && (w_hi < mp_w);
    lo_del = (w_lo < mp_w);
  end

  assign hi_o = en_i && hi_raw && !hi_del;
  assign lo_o = en_i && lo_raw && !lo_del;

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  a_r4_gap_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lo_o) && !$past(load_i) && dead_i != '0) |-> !hi_o);
  a_r4_gap_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hi_o) && !$past(load_i) && dead_i != '0) |-> !lo_o);
endmodule

// File: rtl/pwm3_trip.sv
module pwm3_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic clr_i,
  input  logic load_i,
  output logic off_o
);
  logic trip_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (trip_i) begin
      trip_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (load_i && pend_q) begin
      trip_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_i && trip_q) begin
      pend_q <= 1'b1;
    end
  end

  assign off_o = trip_i || trip_q;

  a_r10_trip_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> trip_q);
  a_r10_release_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_q) |-> $past(load_i));
endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [CNT_W-1:0] minpw_i,
  input  logic [CNT_W-1:0] duty_a_i,
  input  logic [CNT_W-1:0] duty_b_i,
  input  logic [CNT_W-1:0] duty_c_i,
  input  logic             trip_i,
  input  logic             trip_clr_i,
  output logic [NPH-1:0]   hi_o,
  output logic [NPH-1:0]   lo_o,
  output logic             sync_o
);
  logic             load, valid, off, en;
  logic [CNT_W-1:0] fold, half, minpw_s;
  logic [DT_W-1:0]  dead_s;
  logic [NPH-1:0][CNT_W-1:0] duty;

  assign duty = {duty_c_i, duty_b_i, duty_a_i};

  pwm3_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .dead_i(dead_i),
    .minpw_i(minpw_i), .load_o(load), .sync_o(sync_o), .valid_o(valid),
    .fold_o(fold), .half_o(half), .dead_o(dead_s), .minpw_o(minpw_s)
  );

  pwm3_trip u_trip (
    .clk_i(clk_i), .rst_ni(rst_ni), .trip_i(trip_i), .clr_i(trip_clr_i),
    .load_i(load), .off_o(off)
  );

  assign en = valid && !off;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    pwm3_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ph (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .en_i(en),
      .duty_i(duty[g]), .fold_i(fold), .half_i(half), .dead_i(dead_s),
      .minpw_i(minpw_s), .hi_o(hi_o[g]), .lo_o(lo_o[g])
    );
  end

  a_r10_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |-> (hi_o == '0 && lo_o == '0));
endmodule

// File: tb/sim_pwm3_center.sv
module sim_pwm3_center;
  localparam int CNT_W = 12;
  localparam int DT_W  = 10;

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    logic       sync;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = '0, minpw_i = '0;
  logic [DT_W-1:0]  dead_i = '0;
  logic [CNT_W-1:0] duty_a_i = '0, duty_b_i = '0, duty_c_i = '0;
  logic trip_i = 1'b0, trip_clr_i = 1'b0;
  logic [2:0] hi_o, lo_o;
  logic sync_o;

  int n_chk = 0;
  int n_bad = 0;
  item_t q[$];
  item_t it;

  always #5 clk = ~clk;

  pwm3_center #(.CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(period_i), .dead_i(dead_i),
    .minpw_i(minpw_i), .duty_a_i(duty_a_i), .duty_b_i(duty_b_i),
    .duty_c_i(duty_c_i), .trip_i(trip_i), .trip_clr_i(trip_clr_i),
    .hi_o(hi_o), .lo_o(lo_o), .sync_o(sync_o)
  );

  // expected gate pair from the requirement formulas
  function automatic void ref_pair(input int p, input int d, input int dt,
                                   input int mp, input int pos,
                                   output logic h, output logic l);
    int half, c, dh, thr, w;
    half = p / 2;
    c    = (pos < half) ? pos : p - 1 - pos;
    dh   = d / 2;
    thr  = (dh >= half) ? 0 : half - dh;
    if (thr == 0) begin
      h = 1'b1; l = 1'b0;
    end else begin
      w = (half > thr + dt) ? 2 * (half - thr - dt) : 0;
      h = (c >= thr + dt) && (w >= mp);
      l = (c < thr) && (2 * thr >= mp);
    end
  endfunction

  task automatic push_cycle(input string tag, input int p, input int da,
                            input int db, input int dc, input int dt,
                            input int mp, input bit off);
    for (int pos = 0; pos < p; pos++) begin
      item_t e;
      int d3[3];
      d3 = '{da, db, dc};
      for (int k = 0; k < 3; k++) begin
        logic h, l;
        ref_pair(p, d3[k], dt, mp, pos, h, l);
        e.hi[k] = off ? 1'b0 : h;
        e.lo[k] = off ? 1'b0 : l;
      end
      e.sync = (pos == 0);
      e.tag  = tag;
      q.push_back(e);
    end
  endtask

  task automatic wait_sync();
    do begin
      @(posedge clk); #1;
    end while (sync_o !== 1'b1);
  endtask

  task automatic set_in(input int p, input int da, input int db, input int dc,
                        input int dt, input int mp);
    period_i = CNT_W'(p);
    duty_a_i = CNT_W'(da);
    duty_b_i = CNT_W'(db);
    duty_c_i = CNT_W'(dc);
    dead_i   = DT_W'(dt);
    minpw_i  = CNT_W'(mp);
  endtask

  task automatic run_cycles(input string tag, input int p, input int da,
                            input int db, input int dc, input int dt,
                            input int mp, input int n);
    set_in(p, da, db, dc, dt, mp);
    for (int i = 0; i < n; i++) begin
      wait_sync();
      push_cycle(tag, p, da, db, dc, dt, mp, 1'b0);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_off(input string tag);
    n_chk++;
    if (hi_o !== 3'b000 || lo_o !== 3'b000) begin
      n_bad++;
      $display("FAIL %s: hi=%b lo=%b expected hi=000 lo=000", tag, hi_o, lo_o);
    end
  endtask

  // monitor: one queued item per falling edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      it = q.pop_front();
      n_chk++;
      if (hi_o !== it.hi || lo_o !== it.lo || sync_o !== it.sync) begin
        n_bad++;
        $display("FAIL %s: hi=%b lo=%b sync=%b expected hi=%b lo=%b sync=%b",
                 it.tag, hi_o, lo_o, sync_o, it.hi, it.lo, it.sync);
      end
      n_chk++;
      if ((hi_o & lo_o) != 3'b000) begin
        n_bad++;
        $display("FAIL R5: hi=%b lo=%b expected no common bit", hi_o, lo_o);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    set_in(20, 10, 4, 16, 0, 0);
    repeat (2) @(negedge clk);
    check_off("R11");
    n_chk++;
    if (sync_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: sync=%b expected 0", sync_o);
    end
    @(posedge clk); #1 rst_ni = 1'b1;
    // first period right after release; R1 R2 R3 basic shapes
    run_cycles("R11 R1 R2 R3", 20, 10, 4, 16, 0, 0, 2);
    // R4 dead time on both edges
    run_cycles("R4", 20, 10, 6, 14, 2, 0, 2);
    // R6 high deleted on A, R7 low deleted on C
    run_cycles("R6 R7", 20, 8, 12, 18, 2, 6, 2);
    // R8 full on, full off, over-range duty
    run_cycles("R8", 20, 20, 0, 24, 2, 0, 2);
    // R1 new period length
    run_cycles("R1", 16, 6, 10, 2, 1, 0, 2);
    // R9 mid-period rewrite must not disturb current period
    set_in(24, 12, 8, 4, 1, 0);
    wait_sync();
    push_cycle("R9", 24, 12, 8, 4, 1, 0, 1'b0);
    repeat (7) @(posedge clk);
    #1 set_in(24, 20, 2, 14, 3, 0);
    wait_sync();
    push_cycle("R9", 24, 20, 2, 14, 3, 0, 1'b0);
    // R10 fault blanking, latch and release
    drain();
    @(posedge clk); #1 trip_i = 1'b1;
    @(negedge clk); check_off("R10");
    @(posedge clk); #1 trip_i = 1'b0;
    @(negedge clk); check_off("R10");
    wait_sync();
    push_cycle("R10", 24, 20, 2, 14, 3, 0, 1'b1);
    repeat (4) @(posedge clk);
    #1 trip_clr_i = 1'b1;
    @(posedge clk); #1 trip_clr_i = 1'b0;
    run_cycles("R10", 24, 20, 2, 14, 3, 0, 1);
    drain();
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule